// File: doc/BRIEF.md
# Multi-Event Triggered Waveform Buffer

This block records a single channel's stream of 14-bit samples into one sample memory. The memory is divided into a power-of-two number of equal event slots. While acquisition is enabled, one sample is written per clock into the active slot. The slot wraps on itself, so it always holds the most recent window of pre-trigger history.

A trigger is accepted only on an even slot offset, which gives a resolution of two samples. After it, the block writes a programmed number of further samples and then freezes the slot. The very next sample goes to offset zero of the next slot in ring order, so capture has no dead time. Each frozen event keeps three things: a 32-bit time stamp taken from a free-running clock counter, the slot offset of its trigger, and the offset of its last written sample.

A read port walks the oldest frozen event from its oldest sample forward and then releases the slot. When every slot holds an unread event, the block stops writing and reports busy. While busy, any trigger that arrives is dropped and counted.

Top module: `mwb_event_buffer`

## Requirements
- R1: While `run` is high and `busy` is low, one sample is written per clock into the active slot, at an offset that advances by one and wraps modulo the slot size; no sample is written when `run` is low.
- R2: A trigger is accepted only in a cycle whose write offset is even. A trigger seen at an odd offset is held and taken at the next written sample. The stored trigger offset (`ev_trig_off`) is therefore always even.
- R3: After the sample written in the trigger cycle, exactly N further samples are written and then the slot freezes. N is `cfg_post`, clamped to the slot size minus one. Triggers that arrive during this post-trigger window are ignored.
- R4: The sample written in the clock after a freeze goes to offset 0 of the next slot in ring order (slot index plus one, modulo the slot count), with no lost cycle.
- R5: The slot count is 2^k, where k is `cfg_k` clamped to MAX_K. The slot size is 2^AW shifted right by k. Slot i occupies memory addresses i*size to i*size+size-1.
- R6: `busy` is high exactly when all slots hold unread events. While busy, no sample is written, nothing already stored changes, and each cycle with `run` and `trig_in` high increments `drop_count` by one (wrapping).
- R7: `ev_count` equals the number of frozen, unreleased events, and `data_ready` is high exactly when `ev_count` is non-zero.
- R8: A 32-bit time stamp increments every clock and is cleared by `sync`. A `sync` high in one cycle makes the value zero in the next cycle. Each event carries the value the time stamp held in its trigger acceptance cycle.
- R9: Let F be the event's last written offset. For read offset i, the sample at slot offset (F+1+i) modulo the slot size of the oldest event appears on `rd_data` one clock later. A `rd_release` pulse while `data_ready` is high frees that slot, and events are released in capture order.
- R10: After reset, `data_ready`, `busy`, `ev_count` and `drop_count` are zero, and capture starts at offset 0 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Acquisition enable |
| sync | input | 1 | Clears the time stamp counter |
| trig_in | input | 1 | Trigger request, sampled each clock |
| sample_in | input | DW | Incoming sample |
| cfg_k | input | KW | Log2 of the slot count (clamped to MAX_K) |
| cfg_post | input | AW | Post-trigger sample count N |
| rd_off | input | AW | Read offset from the oldest sample of the oldest event |
| rd_release | input | 1 | Frees the oldest event |
| rd_data | output | DW | Sample at `rd_off`, one clock after the offset |
| data_ready | output | 1 | At least one event is waiting |
| busy | output | 1 | All slots hold unread events |
| ev_count | output | MAX_K+1 | Number of stored events |
| ev_ts | output | TSW | Time stamp of the oldest event |
| ev_trig_off | output | AW | Trigger slot offset of the oldest event |
| drop_count | output | DROPW | Triggers dropped while busy |

## Verification
Several properties are checked on every clock:
- no write happens while busy;
- every trigger dropped while busy advances the drop counter;
- a freeze without a release raises the event count by one;
- the active slot never coincides with the oldest stored event;
- the stored trigger offset is even;
- a sync clears the time stamp.

The bench's scenarios are the only place to see the rest: that the right samples land in the right slot, that a freeze occurs exactly N samples after the trigger, that reads start at the oldest pre-trigger sample, and that frozen data stays intact through a busy spell. It shows these by comparing every read sample against a shadow of the written stream, across several slot counts, post-trigger lengths and clamped settings.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  // words in one slot when the memory of 2^aw words holds 2^k slots
  function automatic int buf_words(input int aw, input int k);
    return 1 << (aw - k);
  endfunction

  function automatic int clamp_k(input int k, input int max_k);
    return (k > max_k) ? max_k : k;
  endfunction

  // post-trigger length may not exceed one slot minus the trigger sample
  function automatic int clamp_post(input int post, input int words);
    return (post > words - 1) ? words - 1 : post;
  endfunction

  function automatic int phys_addr(input int aw, input int k, input int idx, input int off);
    return (idx << (aw - k)) | (off & (buf_words(aw, k) - 1));
  endfunction

  // offset of the i-th oldest sample of a slot whose last write was end_off
  function automatic int oldest_off(input int words, input int end_off, input int i);
    return (end_off + 1 + i) & (words - 1);
  endfunction

  function automatic int ring_next(input int idx, input int k);
    return (idx + 1) & ((1 << k) - 1);
  endfunction

endpackage

// File: rtl/mwb_timestamp.sv
module mwb_timestamp #(
  parameter int TSW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync,
  output logic [TSW-1:0] ts_now
);

  logic [TSW-1:0] ts_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ts_q <= '0;
    else if (sync) ts_q <= '0;
    else           ts_q <= ts_q + 1'b1;
  end

  assign ts_now = ts_q;

endmodule

// File: rtl/mwb_sample_ram.sv
module mwb_sample_ram #(
  parameter int AW = 8,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  assign rdata = rd_q;

endmodule

// File: rtl/mwb_capture.sv
module mwb_capture
  import mwb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int MAX_K = 4,
  parameter int KW    = 4,
  parameter int TSW   = 32,
  parameter int DROPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             trig_in,
  input  logic             busy,
  input  logic [KW-1:0]    k_eff,
  input  logic [AW-1:0]    cfg_post,
  input  logic [TSW-1:0]   ts_now,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [MAX_K-1:0] wr_buf,
  output logic             freeze,
  output logic [TSW-1:0]   frz_ts,
  output logic [AW-1:0]    frz_trig,
  output logic [AW-1:0]    frz_end,
  output logic [DROPW-1:0] drop_count
);

  logic [AW-1:0]    off_q, rem_q, trig_lat, post_eff, off_nxt;
  logic [MAX_K-1:0] wb_q, wb_nxt;
  logic [TSW-1:0]   ts_lat;
  logic             inpost_q, pend_q;
  logic             accept, trig_seen, drop_now;
  logic [DROPW-1:0] drop_q;
  int               words;

  always_comb begin
    words     = buf_words(AW, int'(k_eff));
    post_eff  = AW'(clamp_post(int'(cfg_post), words));
    wr_en     = run && !busy;
    trig_seen = trig_in || pend_q;
    accept    = wr_en && !inpost_q && trig_seen && !off_q[0];
    freeze    = (accept && (post_eff == '0)) ||
                (wr_en && inpost_q && (rem_q == AW'(1)));
    drop_now  = run && busy && trig_in;
    off_nxt   = AW'((int'(off_q) + 1) & (words - 1));
    wb_nxt    = MAX_K'(ring_next(int'(wb_q), int'(k_eff)));
    wr_addr   = AW'(phys_addr(AW, int'(k_eff), int'(wb_q), int'(off_q)));
    frz_ts    = accept ? ts_now : ts_lat;
    frz_trig  = accept ? off_q : trig_lat;
    frz_end   = off_q;
    wr_buf    = wb_q;
  end

  // pending trigger: held across an odd offset, dropped when not armed
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (wr_en && !accept && !inpost_q) pend_q <= pend_q || trig_in;
    else pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_lat   <= '0;
      trig_lat <= '0;
    end else if (accept) begin
      ts_lat   <= ts_now;
      trig_lat <= off_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q    <= '0;
      rem_q    <= '0;
      inpost_q <= 1'b0;
      wb_q     <= '0;
    end else if (freeze) begin
      off_q    <= '0;
      inpost_q <= 1'b0;
      wb_q     <= wb_nxt;
    end else if (wr_en) begin
      off_q <= off_nxt;
      if (accept) begin
        inpost_q <= 1'b1;
        rem_q    <= post_eff;
      end else if (inpost_q) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        drop_q <= '0;
    else if (drop_now) drop_q <= drop_q + 1'b1;
  end

  assign drop_count = drop_q;

endmodule

// File: rtl/mwb_ring.sv
module mwb_ring
  import mwb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int MAX_K = 4,
  parameter int KW    = 4,
  parameter int TSW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KW-1:0]    k_eff,
  input  logic             freeze,
  input  logic [MAX_K-1:0] frz_buf,
  input  logic [TSW-1:0]   frz_ts,
  input  logic [AW-1:0]    frz_trig,
  input  logic [AW-1:0]    frz_end,
  input  logic             rd_release,
  output logic             busy,
  output logic             release_ok,
  output logic [MAX_K:0]   ev_count,
  output logic [MAX_K:0]   nbuf,
  output logic [MAX_K-1:0] rd_buf,
  output logic [TSW-1:0]   ev_ts,
  output logic [AW-1:0]    ev_trig,
  output logic [AW-1:0]    ev_end
);

  localparam int NB_MAX = 1 << MAX_K;

  logic [MAX_K:0]   count_q;
  logic [MAX_K-1:0] rb_q;
  logic [TSW-1:0]   slot_ts   [NB_MAX];
  logic [AW-1:0]    slot_trig [NB_MAX];
  logic [AW-1:0]    slot_end  [NB_MAX];

  always_comb begin
    nbuf       = (MAX_K+1)'(1 << int'(k_eff));
    busy       = (count_q == nbuf);
    release_ok = rd_release && (count_q != '0);
  end

  // one descriptor register set per slot
  for (genvar b = 0; b < NB_MAX; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (freeze && (frz_buf == MAX_K'(b))) begin
        slot_ts[b]   <= frz_ts;
        slot_trig[b] <= frz_trig;
        slot_end[b]  <= frz_end;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      rb_q    <= '0;
    end else begin
      case ({freeze, release_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (release_ok) rb_q <= MAX_K'(ring_next(int'(rb_q), int'(k_eff)));
    end
  end

  assign ev_count = count_q;
  assign rd_buf   = rb_q;
  assign ev_ts    = slot_ts[rb_q];
  assign ev_trig  = slot_trig[rb_q];
  assign ev_end   = slot_end[rb_q];

endmodule

// File: rtl/mwb_event_buffer.sv
module mwb_event_buffer
  import mwb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 14,
  parameter int MAX_K = 4,
  parameter int KW    = 4,
  parameter int TSW   = 32,
  parameter int DROPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync,
  input  logic             trig_in,
  input  logic [DW-1:0]    sample_in,
  input  logic [KW-1:0]    cfg_k,
  input  logic [AW-1:0]    cfg_post,
  input  logic [AW-1:0]    rd_off,
  input  logic             rd_release,
  output logic [DW-1:0]    rd_data,
  output logic             data_ready,
  output logic             busy,
  output logic [MAX_K:0]   ev_count,
  output logic [TSW-1:0]   ev_ts,
  output logic [AW-1:0]    ev_trig_off,
  output logic [DROPW-1:0] drop_count
);

  // named internal events, also observed by the bound checker
  logic [KW-1:0]    k_eff;
  logic [TSW-1:0]   ts_now;
  logic             wr_en, freeze, release_ok;
  logic [AW-1:0]    wr_addr, rd_addr, frz_trig, frz_end, ev_end;
  logic [MAX_K-1:0] wr_buf, rd_buf;
  logic [TSW-1:0]   frz_ts;
  logic [MAX_K:0]   nbuf;
  int               words;

  always_comb begin
    k_eff   = KW'(clamp_k(int'(cfg_k), MAX_K));
    words   = buf_words(AW, int'(k_eff));
    rd_addr = AW'(phys_addr(AW, int'(k_eff), int'(rd_buf),
                            oldest_off(words, int'(ev_end), int'(rd_off))));
  end

  mwb_timestamp #(.TSW(TSW)) u_ts (
    .clk(clk), .rst_n(rst_n), .sync(sync), .ts_now(ts_now)
  );

  mwb_capture #(.AW(AW), .MAX_K(MAX_K), .KW(KW), .TSW(TSW), .DROPW(DROPW)) u_cap (
    .clk(clk), .rst_n(rst_n), .run(run), .trig_in(trig_in), .busy(busy),
    .k_eff(k_eff), .cfg_post(cfg_post), .ts_now(ts_now),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_buf(wr_buf), .freeze(freeze),
    .frz_ts(frz_ts), .frz_trig(frz_trig), .frz_end(frz_end),
    .drop_count(drop_count)
  );

  mwb_ring #(.AW(AW), .MAX_K(MAX_K), .KW(KW), .TSW(TSW)) u_ring (
    .clk(clk), .rst_n(rst_n), .k_eff(k_eff), .freeze(freeze), .frz_buf(wr_buf),
    .frz_ts(frz_ts), .frz_trig(frz_trig), .frz_end(frz_end),
    .rd_release(rd_release), .busy(busy), .release_ok(release_ok),
    .ev_count(ev_count), .nbuf(nbuf), .rd_buf(rd_buf),
    .ev_ts(ev_ts), .ev_trig(ev_trig_off), .ev_end(ev_end)
  );

  mwb_sample_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(sample_in),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign data_ready = (ev_count != '0);

endmodule

// File: rtl/mwb_event_buffer_chk.sv
module mwb_event_buffer_chk #(
  parameter int AW    = 8,
  parameter int MAX_K = 4,
  parameter int TSW   = 32,
  parameter int DROPW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             trig_in,
  input logic             sync,
  input logic             busy,
  input logic             data_ready,
  input logic [MAX_K:0]   ev_count,
  input logic [AW-1:0]    ev_trig_off,
  input logic [DROPW-1:0] drop_count,
  input logic             wr_en,
  input logic             freeze,
  input logic             release_ok,
  input logic [MAX_K-1:0] wr_buf,
  input logic [MAX_K-1:0] rd_buf,
  input logic [TSW-1:0]   ts_now,
  input logic [MAX_K:0]   nbuf
);

  assert_busy_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);

  assert_drop_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && busy && trig_in) |=> (drop_count == $past(drop_count) + 1'b1));

  assert_trig_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> !ev_trig_off[0]);

  assert_freeze_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !release_ok) |=> (ev_count == $past(ev_count) + 1'b1));

  assert_ready_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready == (ev_count != '0));

  assert_active_not_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !busy) |-> (wr_buf != rd_buf));

  assert_sync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (ts_now == '0));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_count <= nbuf);

endmodule

bind mwb_event_buffer mwb_event_buffer_chk #(
  .AW(AW), .MAX_K(MAX_K), .TSW(TSW), .DROPW(DROPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .trig_in(trig_in), .sync(sync),
  .busy(busy), .data_ready(data_ready), .ev_count(ev_count),
  .ev_trig_off(ev_trig_off), .drop_count(drop_count), .wr_en(wr_en),
  .freeze(freeze), .release_ok(release_ok), .wr_buf(wr_buf), .rd_buf(rd_buf),
  .ts_now(ts_now), .nbuf(nbuf)
);

// File: tb/mwb_event_buffer_test.sv
module mwb_event_buffer_test;

  localparam int AW = 8, DW = 14, MAX_K = 4, KW = 4, TSW = 32, DROPW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, sync = 1'b0, trig_in = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic [KW-1:0] cfg_k = '0;
  logic [AW-1:0] cfg_post = '0, rd_off = '0;
  logic rd_release = 1'b0;
  logic [DW-1:0] rd_data;
  logic data_ready, busy;
  logic [MAX_K:0] ev_count;
  logic [TSW-1:0] ev_ts;
  logic [AW-1:0] ev_trig_off;
  logic [DROPW-1:0] drop_count;

  mwb_event_buffer #(.AW(AW), .DW(DW), .MAX_K(MAX_K), .KW(KW), .TSW(TSW), .DROPW(DROPW)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .sync(sync), .trig_in(trig_in),
    .sample_in(sample_in), .cfg_k(cfg_k), .cfg_post(cfg_post), .rd_off(rd_off),
    .rd_release(rd_release), .rd_data(rd_data), .data_ready(data_ready),
    .busy(busy), .ev_count(ev_count), .ev_ts(ev_ts), .ev_trig_off(ev_trig_off),
    .drop_count(drop_count)
  );

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit st_on = 1'b0;
  bit drv_done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench view of the configuration
  function automatic int b_k();
    return (int'(cfg_k) > MAX_K) ? MAX_K : int'(cfg_k);
  endfunction
  function automatic int b_nb();
    return 1 << b_k();
  endfunction
  function automatic int b_words();
    return DEPTH / b_nb();
  endfunction
  function automatic int b_post();
    return (int'(cfg_post) > b_words() - 1) ? b_words() - 1 : int'(cfg_post);
  endfunction

  // reference model built from the requirements
  int m_off, m_rem, m_count, m_wb, m_drop;
  bit m_inpost, m_pend;
  logic [31:0] m_ts, m_lts;
  int m_ltrig;
  logic [DW-1:0] sh [DEPTH];
  bit shv [DEPTH];
  logic [31:0] q_ts[$];
  int q_trig[$], q_end[$], q_buf[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_off = 0; m_rem = 0; m_count = 0; m_wb = 0; m_drop = 0;
      m_inpost = 0; m_pend = 0; m_ts = 0; m_lts = 0; m_ltrig = 0;
      q_ts.delete(); q_trig.delete(); q_end.delete(); q_buf.delete();
    end else begin
      logic [31:0] tsc;
      bit bsy, rel, we, acc, frz;
      tsc = m_ts;
      m_ts = sync ? 32'd0 : m_ts + 32'd1;
      bsy = (m_count == b_nb());
      rel = rd_release && (m_count != 0);
      if (run && bsy && trig_in) m_drop = (m_drop + 1) % 65536;
      we  = run && !bsy;
      acc = we && !m_inpost && (trig_in || m_pend) && (m_off % 2 == 0);
      if (!we || acc) m_pend = 0;
      else if (trig_in && !m_inpost) m_pend = 1;
      frz = (acc && b_post() == 0) || (we && m_inpost && m_rem == 1);
      if (we) begin
        sh[m_wb * b_words() + m_off] = sample_in;
        shv[m_wb * b_words() + m_off] = 1'b1;
      end
      if (acc) begin m_lts = tsc; m_ltrig = m_off; end
      if (frz) begin
        q_ts.push_back(m_lts); q_trig.push_back(m_ltrig);
        q_end.push_back(m_off); q_buf.push_back(m_wb);
        m_off = 0; m_inpost = 0; m_wb = (m_wb + 1) % b_nb();
      end else if (we) begin
        m_off = (m_off + 1) % b_words();
        if (acc) begin m_inpost = 1; m_rem = b_post(); end
        else if (m_inpost) m_rem = m_rem - 1;
      end
      if (rel) begin
        void'(q_ts.pop_front()); void'(q_trig.pop_front());
        void'(q_end.pop_front()); void'(q_buf.pop_front());
      end
      m_count = m_count + int'(frz) - int'(rel);
    end
  end

  always @(negedge clk) sample_in <= DW'($urandom);

  // status outputs against the model on every cycle
  always @(negedge clk) begin
    if (rst_n && st_on) begin
      chk(busy === (m_count == b_nb()), "R6 busy flag", longint'(busy), longint'(m_count == b_nb()));
      chk(ev_count === (MAX_K+1)'(m_count), "R7 event count", longint'(ev_count), longint'(m_count));
      chk(data_ready === (m_count != 0), "R7 data ready", longint'(data_ready), longint'(m_count != 0));
      chk(drop_count === DROPW'(m_drop), "R6 drop count", longint'(drop_count), longint'(m_drop));
    end
  end

  task automatic read_event(input string tag);
    int w;
    w = b_words();
    chk(ev_ts === q_ts[0], "R8 event time stamp", longint'(ev_ts), longint'(q_ts[0]));
    chk(ev_trig_off === AW'(q_trig[0]) && !ev_trig_off[0], "R2 trigger offset",
        longint'(ev_trig_off), longint'(q_trig[0]));
    for (int i = 0; i < w; i++) begin
      int a;
      rd_off = AW'(i);
      @(negedge clk);
      a = q_buf[0] * w + ((q_end[0] + 1 + i) % w);
      if (shv[a]) chk(rd_data === sh[a], tag, longint'(rd_data), longint'(sh[a]));
    end
    rd_release = 1'b1;
    @(negedge clk);
    rd_release = 1'b0;
  endtask

  task automatic do_reset(input int k, input int post);
    st_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; trig_in = 1'b0; sync = 1'b0; rd_release = 1'b0;
    cfg_k = KW'(k); cfg_post = AW'(post);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    st_on = 1'b1;
  endtask

  task automatic drive(input int cycles, input int pct);
    run = 1'b1;
    repeat (cycles) begin
      @(negedge clk);
      trig_in = (($urandom % 100) < pct);
    end
    @(negedge clk);
    trig_in = 1'b0;
    drv_done = 1'b1;
  endtask

  task automatic reader(input string tag);
    while (1) begin
      if (data_ready) read_event(tag);
      else if (drv_done) break;
      else @(negedge clk);
    end
  endtask

  task automatic phase(input int k, input int post, input int cycles, input int pct, input string tag);
    do_reset(k, post);
    drv_done = 1'b0;
    fork
      drive(cycles, pct);
      reader(tag);
    join
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(data_ready == 1'b0, "R10 data_ready after reset", longint'(data_ready), 0);
    chk(busy == 1'b0, "R10 busy after reset", longint'(busy), 0);
    chk(ev_count == '0, "R10 ev_count after reset", longint'(ev_count), 0);
    chk(drop_count == '0, "R10 drop_count after reset", longint'(drop_count), 0);

    // directed: sync, then a trigger at odd offset 3 taken at offset 4
    do_reset(1, 2);
    @(negedge clk); run = 1'b1;
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(ev_count == (MAX_K+1)'(1), "R7 one event after directed trigger", longint'(ev_count), 1);
    chk(ev_trig_off == AW'(4), "R2 odd trigger deferred to offset 4", longint'(ev_trig_off), 4);
    chk(ev_ts == 32'd2, "R8 stamp counted from sync", longint'(ev_ts), 2);
    read_event("R3 R9 directed post window");

    phase(2, 5, 3000, 3, "R1 R4 R9 four slots");
    phase(0, 20, 2000, 2, "R1 R9 single slot");
    phase(3, 0, 2000, 3, "R3 R9 zero post samples");
    phase(1, 200, 2000, 1, "R3 R9 clamped post length");
    phase(7, 3, 2000, 3, "R5 R9 clamped slot count");

    // fill every slot, then check busy, drops and intact data
    do_reset(2, 4);
    drv_done = 1'b0;
    drive(1500, 5);
    chk(busy == 1'b1, "R6 busy when all slots full", longint'(busy), 1);
    chk(ev_count == (MAX_K+1)'(4), "R6 four events held", longint'(ev_count), 4);
    chk(drop_count != '0, "R6 triggers dropped while busy", longint'(drop_count), 1);
    while (data_ready) read_event("R6 R9 frozen data kept while busy");
    chk(data_ready == 1'b0, "R7 drained", longint'(data_ready), 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule